// File: doc/BRIEF.md
# Multiprocessor Interrupt Register Block

This block holds the interrupt state for a shared-memory system of up to four processors and turns it into one 4-bit request level per processor. Every processor owns a small register group with a pending word. Software raises bits in that word through a set port and acknowledges them through a clear port, so any processor can post a soft interrupt or a cross-call to any other. A single system group collects device interrupt lines into a system pending word. It also holds a mask, with separate write-only ports to enable and to disable sources, and a target register that picks the one processor to receive unmasked system interrupts.

Device lines are level sensitive and pass through a synchroniser before they reach the system pending word. The register interface is a plain single-cycle request port: a write takes effect on the clock edge that accepts it, and read data is registered and appears on the cycle after the request. The request levels are combinational functions of the register state, so they change right after the edge that changes the state.

Top module: `mp_irq_regs`

## Requirements
- R1: After reset every per-processor pending word is zero, the system mask reads 0xFFFFFFFF (all sources masked), the target reads 0 and every request level is 0.
- R2: The group of processor c starts at byte address c*0x1000. A write to its set port (group offset 0x8) ORs the written ones into its pending word (offset 0x0); zero bits leave pending bits as they were.
- R3: A write to a processor's clear port (group offset 0x4) clears exactly the pending bits written as one and leaves the others unchanged.
- R4: Reads of the write-only ports (processor offsets 0x4 and 0x8, system offsets 0x8 and 0xC) return zero. Any address outside the map (other offsets in a processor group, other offsets from 0x4000, anything above 0x4010) reads zero, and a write there changes no state.
- R5: The system pending word, read at 0x4000, equals the device input lines as seen through a two-stage synchroniser: a line change shows up two clock edges later.
- R6: The system mask reads at 0x4004. Writing ones to 0x400C sets those mask bits (disables the sources); writing ones to 0x4008 clears them (enables the sources); zero bits have no effect.
- R7: The target register at 0x4010 is readable and writable; a written value not below the processor count is ignored and the old target kept.
- R8: Each processor's level is the highest level among its own pending bits, where bit k for k in 1..15 means level k, bit 30 means level 14, bit 31 means level 15, and bits 0 and 16..29 request nothing.
- R9: Unmasked system pending bits add to the level of the target processor only; system bit 31 (memory error) means level 15 and any other system bit k means level (k mod 15)+1.
- R10: Read data appears on the read data port on the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_irq | input | 32 | Level-sensitive device interrupt lines, one per system source |
| cpu_irq_lvl | output | 16 | Request level per processor, 4 bits each, processor 0 in the low bits |

## Verification
A wrong pending or mask bit shows at the level outputs in the same cycle it is stored, because the levels are combinational from the registers; the bench compares all four levels after every access. A target or mask fault that hides a system source only shows once the source is both pending and unmasked, so the random stimulus keeps device lines, mask writes and target writes mixed. Faults in state that has no level effect (bits 0 and 16..29, the synchroniser) are seen on the next read of that register, one cycle after the request.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;

   localparam int unsigned LVL_W = 4;

   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_CPU_PEND,
      SEL_CPU_CLR,
      SEL_CPU_SET,
      SEL_SYS_PEND,
      SEL_SYS_MASK,
      SEL_SYS_EN,
      SEL_SYS_DIS,
      SEL_SYS_TGT
   } reg_sel_e;

   // Level carried by bit k of a processor's own pending word.
   function automatic lvl_t own_bit_level(input int unsigned k);
      if (k >= 1 && k <= 15) return lvl_t'(k);
      else if (k == 30)      return lvl_t'(14);
      else if (k == 31)      return lvl_t'(15);
      else                   return '0;
   endfunction

   // Level carried by bit k of the system pending word.
   function automatic lvl_t sys_bit_level(input int unsigned k);
      if (k == 31) return lvl_t'(15);
      return lvl_t'((k % 15) + 1);
   endfunction

endpackage

// File: rtl/mpirq_decode.sv
module mpirq_decode
   import mpirq_pkg::*;
#(
   parameter int unsigned NUM_CPU   = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned GRP_SHIFT = 12,
   parameter int unsigned SYS_BASE  = 32'h4000,
   parameter int unsigned CPU_IW    = 2
)(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [CPU_IW-1:0] cpu_idx
);

   logic [ADDR_W-1:0]    sys_off;
   logic [ADDR_W-1:0]    grp;
   logic [GRP_SHIFT-1:0] grp_off;

   assign sys_off = addr - ADDR_W'(SYS_BASE);
   assign grp     = addr >> GRP_SHIFT;
   assign grp_off = addr[GRP_SHIFT-1:0];

   always_comb begin
      sel     = SEL_NONE;
      cpu_idx = '0;
      if (addr >= ADDR_W'(SYS_BASE)) begin
         case (sys_off)
            ADDR_W'(32'h00): sel = SEL_SYS_PEND;
            ADDR_W'(32'h04): sel = SEL_SYS_MASK;
            ADDR_W'(32'h08): sel = SEL_SYS_EN;
            ADDR_W'(32'h0C): sel = SEL_SYS_DIS;
            ADDR_W'(32'h10): sel = SEL_SYS_TGT;
            default:         sel = SEL_NONE;
         endcase
      end else if (grp < ADDR_W'(NUM_CPU)) begin
         cpu_idx = CPU_IW'(grp);
         case (grp_off)
            GRP_SHIFT'(0): sel = SEL_CPU_PEND;
            GRP_SHIFT'(4): sel = SEL_CPU_CLR;
            GRP_SHIFT'(8): sel = SEL_CPU_SET;
            default:       sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/mpirq_lvl_enc.sv
module mpirq_lvl_enc
   import mpirq_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          SYS_MAP = 1'b0
)(
   input  logic [DATA_W-1:0] vec,
   output lvl_t              lvl
);

   lvl_t bit_lvl [DATA_W];

   // The parameter picks which bit-to-level table this encoder uses.
   for (genvar k = 0; k < DATA_W; k++) begin : g_map
      if (SYS_MAP) begin : g_sys
         assign bit_lvl[k] = sys_bit_level(k);
      end else begin : g_own
         assign bit_lvl[k] = own_bit_level(k);
      end
   end

   always_comb begin
      lvl = '0;
      for (int k = 0; k < DATA_W; k++) begin
         if (vec[k] && (bit_lvl[k] > lvl)) lvl = bit_lvl[k];
      end
   end

endmodule

// File: rtl/mpirq_cpu_bank.sv
module mpirq_cpu_bank
   import mpirq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_stb,
   input  logic              clr_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] sys_vec,
   output logic [DATA_W-1:0] pend,
   output lvl_t              lvl
);

   lvl_t own_lvl;
   lvl_t sys_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n)       pend <= '0;
      else if (set_stb) pend <= pend | wdata;
      else if (clr_stb) pend <= pend & ~wdata;
   end

   mpirq_lvl_enc #(.DATA_W(DATA_W), .SYS_MAP(1'b0)) u_own (
      .vec (pend),
      .lvl (own_lvl)
   );

   mpirq_lvl_enc #(.DATA_W(DATA_W), .SYS_MAP(1'b1)) u_sys (
      .vec (sys_vec),
      .lvl (sys_lvl)
   );

   assign lvl = (own_lvl > sys_lvl) ? own_lvl : sys_lvl;

   p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((pend & $past(wdata)) == $past(wdata)))
      else $error("set port did not raise the written bits");

   p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((pend & $past(pend)) == $past(pend)))
      else $error("set port dropped a pending bit");

   p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((pend & $past(wdata)) == '0))
      else $error("clear port left a written bit pending");

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(pend))
      else $error("pending word changed without an access");

   p_lvl_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend[31] |-> (lvl == lvl_t'(15)))
      else $error("bit 31 pending but level is not 15");

endmodule

// File: rtl/mpirq_global.sv
module mpirq_global #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_CPU     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CPU_IW      = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] dev_irq,
   input  logic              en_stb,
   input  logic              dis_stb,
   input  logic              tgt_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] gpend,
   output logic [DATA_W-1:0] gmask,
   output logic [CPU_IW-1:0] target
);

   logic [SYNC_STAGES-1:0][DATA_W-1:0] stg;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         if (!rst_n) stg <= '0;
         else        stg <= dev_irq;
      end
   end else begin : g_syncn
      always_ff @(posedge clk) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[SYNC_STAGES-2:0], dev_irq};
      end
   end

   assign gpend = stg[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n)       gmask <= '1;
      else if (dis_stb) gmask <= gmask | wdata;
      else if (en_stb)  gmask <= gmask & ~wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) target <= '0;
      else if (tgt_stb && (wdata < DATA_W'(NUM_CPU))) target <= CPU_IW'(wdata);
   end

   p_mask_dis_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb |=> ((gmask & $past(wdata)) == $past(wdata)))
      else $error("disable port did not mask the written sources");

   p_mask_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_stb |=> ((gmask & $past(wdata)) == '0))
      else $error("enable port did not unmask the written sources");

   p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_stb && !dis_stb) |=> $stable(gmask))
      else $error("mask changed without a mask access");

   p_tgt_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_stb && (wdata >= DATA_W'(NUM_CPU))) |=> $stable(target))
      else $error("out-of-range target value was taken");

   p_tgt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(target) < NUM_CPU)
      else $error("target names a missing processor");

endmodule

// File: rtl/mp_irq_regs.sv
module mp_irq_regs
   import mpirq_pkg::*;
#(
   parameter int unsigned NUM_CPU     = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned GRP_SHIFT   = 12,
   parameter int unsigned SYS_BASE    = 32'h4000,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_valid,
   input  logic                      bus_write,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [DATA_W-1:0]         dev_irq,
   output logic [NUM_CPU*LVL_W-1:0]  cpu_irq_lvl
);

   localparam int unsigned CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

   if (DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 32: bits 30 and 31 carry fixed levels");
   end
   if (NUM_CPU < 1 || NUM_CPU > 16) begin : g_bad_cpus
      $error("NUM_CPU must lie in 1..16");
   end
   if (GRP_SHIFT < 4) begin : g_bad_shift
      $error("GRP_SHIFT too small for a three-word group");
   end
   if (SYS_BASE < (NUM_CPU << GRP_SHIFT)) begin : g_bad_base
      $error("system group overlaps the processor groups");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   reg_sel_e                       sel;
   logic [CPU_IW-1:0]              cpu_idx;
   logic                           wr;
   logic                           rd;
   logic [DATA_W-1:0]              gpend;
   logic [DATA_W-1:0]              gmask;
   logic [CPU_IW-1:0]              target;
   logic [DATA_W-1:0]              routed;
   logic [NUM_CPU-1:0][DATA_W-1:0] pend_arr;
   logic [DATA_W-1:0]              rd_next;

   assign wr = bus_valid && bus_write;
   assign rd = bus_valid && !bus_write;

   mpirq_decode #(
      .NUM_CPU   (NUM_CPU),
      .ADDR_W    (ADDR_W),
      .GRP_SHIFT (GRP_SHIFT),
      .SYS_BASE  (SYS_BASE),
      .CPU_IW    (CPU_IW)
   ) u_dec (
      .addr    (bus_addr),
      .sel     (sel),
      .cpu_idx (cpu_idx)
   );

   mpirq_global #(
      .DATA_W      (DATA_W),
      .NUM_CPU     (NUM_CPU),
      .SYNC_STAGES (SYNC_STAGES),
      .CPU_IW      (CPU_IW)
   ) u_sys (
      .clk     (clk),
      .rst_n   (rst_n),
      .dev_irq (dev_irq),
      .en_stb  (wr && (sel == SEL_SYS_EN)),
      .dis_stb (wr && (sel == SEL_SYS_DIS)),
      .tgt_stb (wr && (sel == SEL_SYS_TGT)),
      .wdata   (bus_wdata),
      .gpend   (gpend),
      .gmask   (gmask),
      .target  (target)
   );

   assign routed = gpend & ~gmask;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic              hit;
      logic [DATA_W-1:0] sys_vec;
      lvl_t              lvl;

      assign hit     = wr && (cpu_idx == CPU_IW'(c));
      assign sys_vec = (target == CPU_IW'(c)) ? routed : '0;

      mpirq_cpu_bank #(.DATA_W(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_stb (hit && (sel == SEL_CPU_SET)),
         .clr_stb (hit && (sel == SEL_CPU_CLR)),
         .wdata   (bus_wdata),
         .sys_vec (sys_vec),
         .pend    (pend_arr[c]),
         .lvl     (lvl)
      );

      assign cpu_irq_lvl[c*LVL_W +: LVL_W] = lvl;

      p_no_stray_sys_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ((target != CPU_IW'(c)) && (pend_arr[c] == '0)) |-> (lvl == '0))
         else $error("non-target processor raised a level with nothing pending");
   end

   always_comb begin
      case (sel)
         SEL_CPU_PEND: rd_next = pend_arr[cpu_idx];
         SEL_SYS_PEND: rd_next = gpend;
         SEL_SYS_MASK: rd_next = gmask;
         SEL_SYS_TGT:  rd_next = DATA_W'(target);
         default:      rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  bus_rdata <= '0;
      else if (rd) bus_rdata <= rd_next;
   end

   p_wo_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (sel inside {SEL_CPU_CLR, SEL_CPU_SET, SEL_SYS_EN, SEL_SYS_DIS, SEL_NONE}))
      |=> (bus_rdata == '0))
      else $error("write-only or unmapped read returned data");

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(bus_rdata))
      else $error("read data moved without a read");

endmodule

// File: tb/mp_irq_regs_test.sv
module mp_irq_regs_test;

   localparam int NCPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] dev_irq = '0;
   logic [15:0] cpu_irq_lvl;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_pend [NCPU];
   logic [31:0] m_gp;
   logic [31:0] m_mask;
   int          m_tgt;

   always #10 clk = ~clk;

   mp_irq_regs uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .dev_irq     (dev_irq),
      .cpu_irq_lvl (cpu_irq_lvl)
   );

   function automatic int lvl_own(int k);
      if (k >= 1 && k <= 15) return k;
      if (k == 30) return 14;
      if (k == 31) return 15;
      return 0;
   endfunction

   function automatic int lvl_sys(int k);
      return (k == 31) ? 15 : (k % 15) + 1;
   endfunction

   function automatic int exp_lvl(int c);
      int best = 0;
      for (int k = 0; k < 32; k++) begin
         if (m_pend[c][k] && lvl_own(k) > best) best = lvl_own(k);
         if (c == m_tgt && m_gp[k] && !m_mask[k] && lvl_sys(k) > best) best = lvl_sys(k);
      end
      return best;
   endfunction

   function automatic logic [31:0] exp_read(logic [15:0] a);
      if (a == 16'h4000) return m_gp;
      if (a == 16'h4004) return m_mask;
      if (a == 16'h4010) return 32'(m_tgt);
      if (a < 16'h4000 && a[11:0] == 12'h000) return m_pend[a[15:12]];
      return 32'h0;
   endfunction

   function automatic void model_write(logic [15:0] a, logic [31:0] d);
      if (a == 16'h4008) m_mask = m_mask & ~d;
      else if (a == 16'h400C) m_mask = m_mask | d;
      else if (a == 16'h4010) begin
         if (d < 32'(NCPU)) m_tgt = int'(d);
      end else if (a < 16'h4000 && a[11:0] == 12'h004) m_pend[a[15:12]] &= ~d;
      else if (a < 16'h4000 && a[11:0] == 12'h008) m_pend[a[15:12]] |= d;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_levels(string req);
      for (int c = 0; c < NCPU; c++)
         check(req, 32'(cpu_irq_lvl[c*4 +: 4]), 32'(exp_lvl(c)));
   endtask

   task automatic bus_wr(logic [15:0] a, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_rd_chk(string req, logic [15:0] a);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      check(req, bus_rdata, exp_read(a));
   endtask

   task automatic set_dev(logic [31:0] v);
      @(negedge clk);
      dev_irq = v;
      repeat (3) @(negedge clk);
      m_gp = v;
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] addrs [14];
      void'($urandom(32'd2718));
      addrs = '{16'h0000, 16'h1000, 16'h2000, 16'h3000, 16'h1004, 16'h2008,
                16'h4000, 16'h4004, 16'h4008, 16'h400C, 16'h4010, 16'h4014,
                16'h100C, 16'h8000};
      for (int c = 0; c < NCPU; c++) m_pend[c] = '0;
      m_gp = '0; m_mask = '1; m_tgt = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check_levels("R1");
      bus_rd_chk("R1", 16'h0000);
      bus_rd_chk("R1", 16'h3000);
      bus_rd_chk("R1", 16'h4004);
      bus_rd_chk("R1", 16'h4010);

      // R2 set port raises only written ones; R8 bit 30 is level 14
      bus_wr(16'h1008, 32'h4000_0020);
      bus_rd_chk("R2", 16'h1000);
      check_levels("R8");
      bus_wr(16'h1008, 32'h0000_0008);
      bus_rd_chk("R2", 16'h1000);

      // R3 clear drops only written ones
      bus_wr(16'h1004, 32'h4000_0000);
      bus_rd_chk("R3", 16'h1000);
      check_levels("R3");

      // R8 bits with no level, bit 31 is level 15
      bus_wr(16'h3008, 32'h3FFF_0001);
      check_levels("R8");
      bus_wr(16'h3008, 32'h8000_0000);
      check_levels("R8");

      // R4 write-only and unmapped addresses
      bus_rd_chk("R4", 16'h1004);
      bus_rd_chk("R4", 16'h1008);
      bus_rd_chk("R4", 16'h4008);
      bus_rd_chk("R4", 16'h400C);
      bus_wr(16'h100C, 32'hFFFF_FFFF);
      bus_wr(16'h4014, 32'hFFFF_FFFF);
      bus_wr(16'h8008, 32'hFFFF_FFFF);
      bus_rd_chk("R4", 16'h100C);
      bus_rd_chk("R4", 16'h4014);
      bus_rd_chk("R4", 16'h1000);
      bus_rd_chk("R4", 16'h4004);
      check_levels("R4");

      // R5 synchroniser, R6 mask, R9 routing of memory error bit 31
      set_dev(32'h8000_0000);
      bus_rd_chk("R5", 16'h4000);
      check_levels("R6");
      bus_wr(16'h4008, 32'h8000_0000);
      bus_rd_chk("R6", 16'h4004);
      check_levels("R9");

      // R7 target move and out-of-range write ignored
      bus_wr(16'h4010, 32'd2);
      bus_rd_chk("R7", 16'h4010);
      check_levels("R9");
      bus_wr(16'h4010, 32'd7);
      bus_rd_chk("R7", 16'h4010);
      bus_wr(16'h400C, 32'h8000_0000);
      check_levels("R6");

      // R10 read data holds until the next read
      bus_rd_chk("R10", 16'h4010);
      bus_wr(16'h4010, 32'd1);
      repeat (2) @(negedge clk);
      check("R10", bus_rdata, 32'd2);

      // Random mix
      for (int i = 0; i < 600; i++) begin
         int op = int'($urandom_range(0, 7));
         case (op)
            0: bus_wr(16'((int'($urandom_range(0, 3)) << 12) | 8), $urandom);
            1: bus_wr(16'((int'($urandom_range(0, 3)) << 12) | 4), $urandom);
            2: bus_wr(16'h4008, $urandom & $urandom);
            3: bus_wr(16'h400C, $urandom & $urandom);
            4: bus_wr(16'h4010, 32'($urandom_range(0, 6)));
            5: set_dev($urandom);
            6: bus_rd_chk("R2", addrs[$urandom_range(0, 13)]);
            default: bus_rd_chk("R4", 16'($urandom));
         endcase
         check_levels("R9");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule